// File: doc/BRIEF.md
# USB Host Frame Marker Generator

This block paces the 1 ms frames of a USB host. It counts ticks of a bit-clock enable that runs at the 12 MHz full-speed bit rate, and at every frame boundary it emits one frame marker. At full speed the marker is a start-of-frame token, built from the fixed token PID, the current 11-bit frame number and a CRC5 over that number. The token leaves as a 24-bit word with a one-cycle valid strobe, ready for a downstream serializer that applies NRZI and drives the bus. At low speed the same timer produces a one-cycle keep-alive request instead. No token is built and the frame number does not move.

Control logic turns marker generation on and off with a level enable. It restarts the numbering with a one-cycle reset pulse, and it acknowledges the sticky frame interrupt with a one-cycle clear pulse. A frame strobe and a busy level are also provided for other logic. Busy is high for a fixed number of bit ticks after each marker. If the enable is dropped while busy is high, that marker still runs to the end, and no later marker is issued.

Top module: `usb_frame_marker`

## Requirements
- R1: While reset is held and in the first cycle after it, tok_valid, keepalive, frame_pulse, marker_busy and frame_irq are all 0. The first SOF after reset carries frame number 0.
- R2: A rise of mark_en (seen with the block idle) gives a first marker two clock edges later. While mark_en stays high, later markers follow every TICKS_PER_FRAME cycles in which bit_tick is high (12000 by default, i.e. 1 ms). Cycles with bit_tick low do not advance the timer.
- R3: A full-speed marker sets tok_valid for one cycle. In that cycle tok_data holds the PID 0xA5 in bits [7:0], the frame number in bits [18:8] and the CRC5 in bits [23:19]. The token goes out LSB first, so the order on the wire is PID, frame number, CRC. tok_data does not change between markers.
- R4: The CRC5 uses the polynomial x^5+x^2+1. The register starts at all ones, the frame number is fed in LSB first, and the register is inverted at the end. Bit 19 of tok_data holds the CRC bit that is sent first.
- R5: After each SOF the frame number goes up by one, modulo 2048.
- R6: With low_speed high at a frame boundary, keepalive pulses for one cycle, tok_valid stays low and the frame number is left unchanged.
- R7: After a fn_reset pulse, the next SOF carries frame number 0 and the one after it carries 1. A pulse in the same cycle as an SOF does not change that SOF; it applies to the next one.
- R8: marker_busy goes high with each marker and stays high for MARK_TICKS bit ticks.
- R9: Once mark_en is low, no new marker is issued. A marker that is busy when mark_en falls still keeps marker_busy high for its full MARK_TICKS ticks.
- R10: frame_irq is set with each marker and holds until an irq_clr pulse clears it. If a marker and a clear arrive in the same cycle, the set wins.
- R11: frame_pulse is high for exactly the one cycle of each marker, of either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Bit-clock enable (12 MHz rate) |
| mark_en | input | 1 | Frame marker generation enable |
| low_speed | input | 1 | 1 selects keep-alive markers, 0 selects SOF tokens |
| fn_reset | input | 1 | Pulse: next SOF carries frame number 0 |
| irq_clr | input | 1 | Pulse: clear frame_irq |
| tok_valid | output | 1 | One-cycle strobe for a new SOF token |
| tok_data | output | 24 | SOF token, LSB sent first |
| keepalive | output | 1 | One-cycle keep-alive request |
| frame_pulse | output | 1 | One-cycle strobe at each frame marker |
| marker_busy | output | 1 | High while a frame marker is in progress |
| frame_irq | output | 1 | Sticky frame interrupt |

## Verification
The bound checker enforces several rules on every cycle:
- the two marker kinds never appear together, and each matches the low_speed level at the boundary;
- every marker comes with frame_pulse, a set frame_irq and a fixed PID;
- no marker appears without a prior enable;
- the token word stays stable between markers.

Frame spacing, CRC values, frame number sequence and wrap, numbering reset, busy length and disable behaviour all depend on history longer than a few cycles. These come only from the bench's scenarios. The bench runs a short-frame configuration through every one of the 2048 frame numbers and computes each CRC with an independent reflected algorithm.

// File: rtl/usbfm_pkg.sv
package usbfm_pkg;
   localparam int FN_W   = 11;
   localparam int CRC_W  = 5;
   localparam int PID_W  = 8;
   localparam int TOK_W  = PID_W + FN_W + CRC_W;
   localparam logic [PID_W-1:0] SOF_PID = 8'hA5;
   typedef logic [FN_W-1:0]  fnum_t;
   typedef logic [CRC_W-1:0] crc_t;
   typedef logic [TOK_W-1:0] token_t;
endpackage

// File: rtl/usbfm_crc5.sv
module usbfm_crc5
   import usbfm_pkg::*;
#(
   parameter int DW = FN_W
) (
   input  logic [DW-1:0] data_i,
   output crc_t          crc_o
);
   // stage k holds the shift register after k data bits, LSB first
   crc_t stage [DW+1];
   assign stage[0] = '1;

   for (genvar k = 0; k < DW; k++) begin : g_bit
      logic fb;
      assign fb = data_i[k] ^ stage[k][CRC_W-1];
      assign stage[k+1] = {stage[k][CRC_W-2:0], 1'b0} ^ {2'b00, fb, 1'b0, fb};
   end

   // inverted remainder, reordered so bit 0 is the first bit sent
   for (genvar i = 0; i < CRC_W; i++) begin : g_out
      assign crc_o[i] = ~stage[DW][CRC_W-1-i];
   end
endmodule

// File: rtl/usbfm_timer.sv
module usbfm_timer #(
   parameter int TICKS_PER_FRAME = 12000,
   parameter int MARK_TICKS      = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic enable_i,
   output logic boundary_o,
   output logic pulse_o,
   output logic busy_o
);
   localparam int CW = $clog2(TICKS_PER_FRAME);
   localparam int MW = $clog2(MARK_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_FRAME - 1);

   logic          running_q;
   logic [CW-1:0] cnt_q;
   logic [MW-1:0] bcnt_q;

   assign busy_o     = (bcnt_q != '0);
   assign boundary_o = running_q && enable_i && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cnt_q     <= '0;
         pulse_o   <= 1'b0;
      end else begin
         pulse_o <= boundary_o;
         if (!running_q) begin
            if (enable_i) begin
               running_q <= 1'b1;
               cnt_q     <= LAST;
            end
         end else if (!enable_i && !busy_o) begin
            running_q <= 1'b0;
         end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bcnt_q <= '0;
      else if (boundary_o)           bcnt_q <= MW'(MARK_TICKS);
      else if (tick_i && busy_o)     bcnt_q <= bcnt_q - 1'b1;
   end
endmodule

// File: rtl/usbfm_sofgen.sv
module usbfm_sofgen
   import usbfm_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   boundary_i,
   input  logic   low_speed_i,
   input  logic   fn_reset_i,
   output logic   tok_valid_o,
   output token_t tok_data_o,
   output logic   keepalive_o
);
   fnum_t frame_q;
   crc_t  crc;
   logic  sof_now;

   assign sof_now = boundary_i && !low_speed_i;

   usbfm_crc5 #(.DW(FN_W)) u_crc (
      .data_i (frame_q),
      .crc_o  (crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q     <= '0;
         tok_data_o  <= '0;
         tok_valid_o <= 1'b0;
         keepalive_o <= 1'b0;
      end else begin
         tok_valid_o <= sof_now;
         keepalive_o <= boundary_i && low_speed_i;
         if (sof_now) tok_data_o <= {crc, frame_q, SOF_PID};
         if (fn_reset_i)   frame_q <= '0;
         else if (sof_now) frame_q <= frame_q + 1'b1;
      end
   end
endmodule

// File: rtl/usb_frame_marker.sv
module usb_frame_marker
   import usbfm_pkg::*;
#(
   parameter int TICKS_PER_FRAME = 12000,
   parameter int MARK_TICKS      = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              mark_en,
   input  logic              low_speed,
   input  logic              fn_reset,
   input  logic              irq_clr,
   output logic              tok_valid,
   output logic [TOK_W-1:0]  tok_data,
   output logic              keepalive,
   output logic              frame_pulse,
   output logic              marker_busy,
   output logic              frame_irq
);
   if (TICKS_PER_FRAME < 2) begin : g_bad_frame
      $error("TICKS_PER_FRAME must be at least 2");
   end
   if (MARK_TICKS < 1 || MARK_TICKS >= TICKS_PER_FRAME) begin : g_bad_mark
      $error("MARK_TICKS must lie in 1 .. TICKS_PER_FRAME-1");
   end

   logic   boundary;
   token_t tok;

   usbfm_timer #(
      .TICKS_PER_FRAME (TICKS_PER_FRAME),
      .MARK_TICKS      (MARK_TICKS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (bit_tick),
      .enable_i   (mark_en),
      .boundary_o (boundary),
      .pulse_o    (frame_pulse),
      .busy_o     (marker_busy)
   );

   usbfm_sofgen u_sof (
      .clk         (clk),
      .rst_n       (rst_n),
      .boundary_i  (boundary),
      .low_speed_i (low_speed),
      .fn_reset_i  (fn_reset),
      .tok_valid_o (tok_valid),
      .tok_data_o  (tok),
      .keepalive_o (keepalive)
   );
   assign tok_data = tok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame_irq <= 1'b0;
      else if (boundary) frame_irq <= 1'b1;
      else if (irq_clr)  frame_irq <= 1'b0;
   end
endmodule

// File: rtl/usbfm_chk.sv
module usbfm_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mark_en,
   input logic        low_speed,
   input logic        irq_clr,
   input logic        tok_valid,
   input logic [23:0] tok_data,
   input logic        keepalive,
   input logic        frame_pulse,
   input logic        marker_busy,
   input logic        frame_irq
);
   p_kind_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tok_valid && keepalive));
   p_ls_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      keepalive |-> $past(low_speed));
   p_fs_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |-> (!$past(low_speed) && tok_data[7:0] == 8'hA5));
   p_tok_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |-> $stable(tok_data));
   p_pulse_has_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> (tok_valid || keepalive));
   p_kind_has_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid || keepalive) |-> frame_pulse);
   p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> frame_irq);
   p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq_clr) && !frame_pulse) |-> !frame_irq);
   p_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |-> $past(mark_en));
   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(marker_busy) |-> frame_pulse);
endmodule

bind usb_frame_marker usbfm_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mark_en     (mark_en),
   .low_speed   (low_speed),
   .irq_clr     (irq_clr),
   .tok_valid   (tok_valid),
   .tok_data    (tok_data),
   .keepalive   (keepalive),
   .frame_pulse (frame_pulse),
   .marker_busy (marker_busy),
   .frame_irq   (frame_irq)
);

// File: tb/sim_usb_frame_marker.sv
module sim_usb_frame_marker;
   localparam int TPF  = 20;
   localparam int MARK = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b1;
   logic        mark_en = 1'b0;
   logic        low_speed = 1'b0;
   logic        fn_reset = 1'b0;
   logic        irq_clr = 1'b0;
   logic        tok_valid, keepalive, frame_pulse, marker_busy, frame_irq;
   logic [23:0] tok_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_mark = 0;
   int exp_fn = 0;
   bit half_rate = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) bit_tick <= half_rate ? ~bit_tick : 1'b1;

   usb_frame_marker #(.TICKS_PER_FRAME(TPF), .MARK_TICKS(MARK)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mark_en(mark_en),
      .low_speed(low_speed), .fn_reset(fn_reset), .irq_clr(irq_clr),
      .tok_valid(tok_valid), .tok_data(tok_data), .keepalive(keepalive),
      .frame_pulse(frame_pulse), .marker_busy(marker_busy), .frame_irq(frame_irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // reflected CRC5: poly 0x14, result bit 0 is sent first
   function automatic logic [4:0] ref_crc(input int fn);
      logic [4:0] c = 5'h1F;
      for (int i = 0; i < 11; i++) begin
         if ((c[0] ^ fn[i]) == 1'b1) c = (c >> 1) ^ 5'h14;
         else                        c = c >> 1;
      end
      return ~c;
   endfunction

   function automatic logic [23:0] exp_tok(input int fn);
      return {ref_crc(fn), fn[10:0], 8'hA5};
   endfunction

   // advance to the next marker; returns cycles since the previous one
   task automatic next_marker(output int gap);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!frame_pulse && n < 2000);
      if (n >= 2000) chk(1'b0, "R2 marker timeout", 0, 1);
      gap = cyc - last_mark;
      last_mark = cyc;
   endtask

   task automatic check_sof(input string req);
      chk(tok_valid === 1'b1 && keepalive === 1'b0, {req, " kind"}, {tok_valid, keepalive}, 2);
      chk(tok_data === exp_tok(exp_fn), {req, " token"}, tok_data, exp_tok(exp_fn));
      exp_fn = (exp_fn + 1) % 2048;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int gap, cnt;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({tok_valid, keepalive, frame_pulse, marker_busy, frame_irq} === 5'b0, "R1 in reset",
          {tok_valid, keepalive, frame_pulse, marker_busy, frame_irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({tok_valid, keepalive, frame_pulse, marker_busy, frame_irq} === 5'b0, "R1 after reset",
          {tok_valid, keepalive, frame_pulse, marker_busy, frame_irq}, 0);

      // R2 first marker latency
      mark_en = 1'b1;
      last_mark = cyc;
      next_marker(gap);
      chk(gap == 2, "R2 first latency", gap, 2);
      check_sof("R1 first frame number zero");
      chk(marker_busy === 1'b1 && frame_irq === 1'b1, "R8 R10 set at marker",
          {marker_busy, frame_irq}, 3);

      // R3 R4 R5 R11: full sweep through all frame numbers and the wrap
      for (int k = 0; k < 2050; k++) begin
         next_marker(gap);
         chk(gap == TPF, "R2 period", gap, TPF);
         check_sof("R3 R4 R5 sweep");
      end

      // R8 busy length
      next_marker(gap);
      check_sof("R3 busy frame");
      cnt = 0;
      for (int i = 0; i < TPF - 2; i++) begin
         if (marker_busy) cnt++;
         @(negedge clk);
      end
      chk(cnt == MARK, "R8 busy length", cnt, MARK);
      chk(frame_irq === 1'b1, "R10 sticky", frame_irq, 1);

      // R10 clear mid-frame
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      chk(frame_irq === 1'b0, "R10 clear", frame_irq, 0);
      next_marker(gap);
      check_sof("R3 after clear");
      chk(frame_irq === 1'b1, "R10 set again", frame_irq, 1);
      // R10 set wins over clear in same cycle
      repeat (TPF - 1) @(negedge clk);
      irq_clr = 1'b1;
      next_marker(gap);
      irq_clr = 1'b0;
      chk(gap == TPF, "R10 collision timing", gap, TPF);
      chk(frame_irq === 1'b1, "R10 set wins", frame_irq, 1);
      check_sof("R3 collision frame");

      // R7 frame number reset mid-frame
      repeat (5) @(negedge clk);
      fn_reset = 1'b1; @(negedge clk); fn_reset = 1'b0;
      exp_fn = 0;
      next_marker(gap);
      check_sof("R7 zero after reset");
      next_marker(gap);
      check_sof("R7 one after zero");
      // R7 reset in same cycle as SOF applies to the following SOF
      repeat (TPF - 1) @(negedge clk);
      fn_reset = 1'b1;
      next_marker(gap);
      fn_reset = 1'b0;
      check_sof("R7 coincident keeps value");
      exp_fn = 0;
      next_marker(gap);
      check_sof("R7 coincident applies next");

      // R6 low speed keep-alive, frame number frozen
      repeat (5) @(negedge clk);
      low_speed = 1'b1;
      for (int k = 0; k < 3; k++) begin
         next_marker(gap);
         chk(keepalive === 1'b1 && tok_valid === 1'b0, "R6 keep-alive kind",
             {keepalive, tok_valid}, 2);
         chk(gap == TPF, "R6 period", gap, TPF);
      end
      repeat (5) @(negedge clk);
      low_speed = 1'b0;
      next_marker(gap);
      check_sof("R6 number unchanged");

      // R2 tick gating: half-rate bit ticks double the spacing
      half_rate = 1'b1;
      next_marker(gap);
      check_sof("R2 half rate");
      for (int k = 0; k < 3; k++) begin
         next_marker(gap);
         chk(gap == 2 * TPF, "R2 gated period", gap, 2 * TPF);
         check_sof("R2 half rate");
      end
      half_rate = 1'b0;
      next_marker(gap);
      check_sof("R2 back to full rate");

      // R9 disable during busy: marker completes, nothing after
      next_marker(gap);
      check_sof("R9 last marker");
      mark_en = 1'b0;
      cnt = 1;
      for (int i = 0; i < 3 * TPF; i++) begin
         @(negedge clk);
         if (marker_busy) cnt++;
         if (frame_pulse) chk(1'b0, "R9 marker after disable", 1, 0);
      end
      chk(cnt == MARK, "R9 busy completes", cnt, MARK);
      chk(marker_busy === 1'b0, "R9 idle", marker_busy, 0);

      // R9 re-enable then disable mid-frame
      mark_en = 1'b1;
      last_mark = cyc;
      next_marker(gap);
      chk(gap == 2, "R2 restart latency", gap, 2);
      check_sof("R9 restart");
      repeat (8) @(negedge clk);
      mark_en = 1'b0;
      cnt = 0;
      for (int i = 0; i < 3 * TPF; i++) begin
         @(negedge clk);
         if (frame_pulse) cnt++;
      end
      chk(cnt == 0, "R9 stopped mid-frame", cnt, 0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule